// File: doc/BRIEF.md
# Write-Through Private Cache with Exclusivity Token

This block is a core's private data cache in a scheme where a shared cache level sorts every line into one of two classes. The first class is private or read-only, and those lines may be cached near the core. The second class is shared and written, and those lines live only at the shared level. The cache is direct-mapped and holds one data word per line. Each line has a valid bit and a single exclusivity token bit, and no multi-bit coherence state. Each store is written through to the shared level. The write message reports whether this cache holds the token for the line. When a line that holds the token is replaced, the cache first sends a message that hands the token back.

The shared level controls placement in two ways. First, each read response carries a cacheable flag and a token-grant flag. A response that is not cacheable is passed to the core but is never installed. Second, an invalidation input removes a line that has just become shared and written. If that invalidation names a read that is still outstanding, the returned word goes to the core and the line is not installed.

The core request and the request port to the shared level both follow valid/ready rules. A request transfers on a clock edge where valid and ready are both high. While valid is high and ready is low, the sender keeps valid and every payload field unchanged. A store is complete when it transfers, so the core stalls until the write message is accepted. The core response and the shared-level response are valid-only pulses, and the receiver must take them in that cycle. The invalidation input is a plain one-cycle strobe.

Top module: `wt_token_cache`

## Requirements
- R1: After reset, no line is valid, `core_rsp_valid` and `sh_req_valid` are low, and `core_req_ready` is high while no store is presented.
- R2: A load whose line is valid with a matching tag returns the stored word with `core_rsp_valid` in the cycle after acceptance, and sends nothing to the shared level.
- R3: A load miss sends one read message (kind 2'b00) carrying the word address. The response data reaches the core in the cycle after `sh_rsp_valid`. If the response is cacheable, the line is installed with its token bit set to `sh_rsp_token`.
- R4: A load miss whose index holds a valid line with the token set first sends a token-return message (kind 2'b10, tok 1) for the old line's address, and only then sends the read. A valid victim without the token is dropped silently.
- R5: Every store sends one write message (kind 2'b01) with the address and data. Its tok field is 1 exactly when the line is cached here with the token set. For a store, `core_req_ready` equals `sh_req_ready`.
- R6: A store that hits updates the local word. A store that misses allocates nothing.
- R7: A response with `sh_rsp_cacheable` low is forwarded to the core but not installed, so the next load to that address misses again.
- R8: An invalidation whose address matches a valid cached line removes that line. An invalidation to any other address changes nothing.
- R9: An invalidation that matches the address of an outstanding load miss cancels the install. The data is still forwarded.
- R10: While `sh_req_valid` is high and `sh_req_ready` is low, the next cycle keeps `sh_req_valid` high with the same kind and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Core request accepted this cycle |
| core_req_we | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | ADDR_W | Word address |
| core_req_wdata | input | DATA_W | Store data |
| core_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| core_rsp_rdata | output | DATA_W | Load data |
| sh_req_valid | output | 1 | Message to shared level valid |
| sh_req_ready | input | 1 | Shared level accepts message |
| sh_req_kind | output | 2 | 00 read, 01 write, 10 token return |
| sh_req_addr | output | ADDR_W | Message word address |
| sh_req_wdata | output | DATA_W | Write data (zero for other kinds) |
| sh_req_tok | output | 1 | Token held (write) / token returned (return) |
| sh_rsp_valid | input | 1 | Read response valid |
| sh_rsp_rdata | input | DATA_W | Read response data |
| sh_rsp_cacheable | input | 1 | Response may be installed |
| sh_rsp_token | input | 1 | Token granted with the fill |
| inv_valid | input | 1 | Invalidation strobe |
| inv_addr | input | ADDR_W | Invalidated word address |

## Verification
Some rules are checked on every cycle. A token bit is never set on an invalid line. A matching invalidation clears its line on the next edge. A store cannot be accepted while the shared port is stalled. A stalled message keeps its kind and address. A token return is always followed by the read request. A read response always produces a core response on the next cycle. Other behaviour shows only across a sequence of operations, so the bench scenarios cover it. That includes whether a line was installed or left out after a non-cacheable or cancelled fill, the tok value reported by later writes, and silent victim drops. The bench drives such sequences against a behavioural model of lines, tags and tokens under a varying ready pattern.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    MSG_READ   = 2'b00,
    MSG_WRITE  = 2'b01,
    MSG_TOKRET = 2'b10
  } msg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_RET    = 2'b01,
    ST_RDREQ  = 2'b10,
    ST_RDWAIT = 2'b11
  } ctrl_state_e;
endpackage

// File: rtl/wtc_lines.sv
module wtc_lines #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic              lk_tok,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_data,
  input  logic              drop_en,
  input  logic [IDX_W-1:0]  drop_idx,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_tok,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic [TAG_W-1:0]  inv_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  tok_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign lk_valid = valid_q[lk_idx];
  assign lk_tok   = tok_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];
  assign lk_data  = data_q[lk_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic inv_hit;
    assign inv_hit = inv_en && (inv_idx == IDX_W'(i)) && valid_q[i] && (tag_q[i] == inv_tag);

    // Valid and token state; an invalidation overrides any same-cycle update.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        tok_q[i]   <= 1'b0;
      end else begin
        if (drop_en && drop_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
          tok_q[i]   <= 1'b0;
        end
        if (fill_en && fill_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          tok_q[i]   <= fill_tok;
        end
        if (inv_hit) begin
          valid_q[i] <= 1'b0;
          tok_q[i]   <= 1'b0;
        end
      end
    end

    // Tag and data carry no reset; they are qualified by valid.
    always_ff @(posedge clk) begin
      if (fill_en && fill_idx == IDX_W'(i)) begin
        tag_q[i]  <= fill_tag;
        data_q[i] <= fill_data;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        data_q[i] <= wr_data;
      end
    end

    // R1: a token is only ever held on a valid line
    a_r1_tok_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tok_q[i] |-> valid_q[i]);

    // R8: a matching invalidation empties the line on the next edge
    a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && inv_idx == IDX_W'(i) && valid_q[i] && tag_q[i] == inv_tag) |=> !valid_q[i]);
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    core_req_valid,
  output logic                    core_req_ready,
  input  logic                    core_req_we,
  input  logic [ADDR_W-1:0]       core_req_addr,
  input  logic [DATA_W-1:0]       core_req_wdata,
  output logic                    core_rsp_valid,
  output logic [DATA_W-1:0]       core_rsp_rdata,
  output logic                    sh_req_valid,
  input  logic                    sh_req_ready,
  output logic [1:0]              sh_req_kind,
  output logic [ADDR_W-1:0]       sh_req_addr,
  output logic [DATA_W-1:0]       sh_req_wdata,
  output logic                    sh_req_tok,
  input  logic                    sh_rsp_valid,
  input  logic [DATA_W-1:0]       sh_rsp_rdata,
  input  logic                    sh_rsp_cacheable,
  input  logic                    sh_rsp_token,
  input  logic                    inv_valid,
  input  logic [ADDR_W-1:0]       inv_addr,
  output logic [IDX_W-1:0]        lk_idx,
  input  logic                    lk_valid,
  input  logic                    lk_tok,
  input  logic [ADDR_W-IDX_W-1:0] lk_tag,
  input  logic [DATA_W-1:0]       lk_data,
  output logic                    drop_en,
  output logic                    fill_en,
  output logic [IDX_W-1:0]        fill_idx,
  output logic [ADDR_W-IDX_W-1:0] fill_tag,
  output logic                    wr_en
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctrl_state_e       state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [ADDR_W-1:0] vict_addr_q;
  logic              cancel_q;
  logic              rsp_v_q;
  logic [DATA_W-1:0] rsp_d_q;

  logic [TAG_W-1:0]  req_tag;
  logic              hit;
  logic              is_idle;
  logic              accept;
  logic              inv_pend;

  assign lk_idx   = core_req_addr[IDX_W-1:0];
  assign req_tag  = core_req_addr[ADDR_W-1:IDX_W];
  assign hit      = lk_valid && (lk_tag == req_tag);
  assign is_idle  = (state_q == ST_IDLE);
  assign core_req_ready = is_idle && (core_req_we ? sh_req_ready : 1'b1);
  assign accept   = core_req_valid && core_req_ready;
  assign inv_pend = inv_valid && (inv_addr == pend_addr_q);

  assign wr_en    = accept && core_req_we && hit;
  assign drop_en  = accept && !core_req_we && !hit && lk_valid;
  assign fill_idx = pend_addr_q[IDX_W-1:0];
  assign fill_tag = pend_addr_q[ADDR_W-1:IDX_W];
  assign fill_en  = (state_q == ST_RDWAIT) && sh_rsp_valid && sh_rsp_cacheable
                    && !cancel_q && !inv_pend;

  assign core_rsp_valid = rsp_v_q;
  assign core_rsp_rdata = rsp_d_q;

  // Message mux onto the shared-level request port
  always_comb begin
    sh_req_valid = 1'b0;
    sh_req_kind  = MSG_READ;
    sh_req_addr  = pend_addr_q;
    sh_req_wdata = '0;
    sh_req_tok   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sh_req_valid = core_req_valid && core_req_we;
        sh_req_kind  = MSG_WRITE;
        sh_req_addr  = core_req_addr;
        sh_req_wdata = core_req_wdata;
        sh_req_tok   = hit && lk_tok;
      end
      ST_RET: begin
        sh_req_valid = 1'b1;
        sh_req_kind  = MSG_TOKRET;
        sh_req_addr  = vict_addr_q;
        sh_req_tok   = 1'b1;
      end
      ST_RDREQ: begin
        sh_req_valid = 1'b1;
        sh_req_kind  = MSG_READ;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_addr_q <= '0;
      vict_addr_q <= '0;
      cancel_q    <= 1'b0;
      rsp_v_q     <= 1'b0;
      rsp_d_q     <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && !core_req_we) begin
            if (hit) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= lk_data;
            end else begin
              pend_addr_q <= core_req_addr;
              vict_addr_q <= {lk_tag, lk_idx};
              cancel_q    <= inv_valid && (inv_addr == core_req_addr);
              state_q     <= (lk_valid && lk_tok) ? ST_RET : ST_RDREQ;
            end
          end
        end
        ST_RET: begin
          cancel_q <= cancel_q || inv_pend;
          if (sh_req_ready) state_q <= ST_RDREQ;
        end
        ST_RDREQ: begin
          cancel_q <= cancel_q || inv_pend;
          if (sh_req_ready) state_q <= ST_RDWAIT;
        end
        default: begin
          cancel_q <= cancel_q || inv_pend;
          if (sh_rsp_valid) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= sh_rsp_rdata;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R10: a stalled message holds kind and address
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_req_valid && !sh_req_ready) |=>
      (sh_req_valid && $stable(sh_req_kind) && $stable(sh_req_addr)));

  // R4: an accepted token return is followed by the read request
  a_r4_ret_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_req_valid && sh_req_ready && sh_req_kind == MSG_TOKRET) |=>
      (sh_req_valid && sh_req_kind == MSG_READ));

  // R5: a store cannot be taken while the shared port stalls
  a_r5_store_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && core_req_we && !sh_req_ready) |-> !core_req_ready);

  // R3: a read response reaches the core on the next cycle
  a_r3_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDWAIT && sh_rsp_valid) |=> core_rsp_valid);

  // R2: a load hit answers on the next cycle
  a_r2_hit_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !core_req_we && hit) |=> core_rsp_valid);
endmodule

// File: rtl/wt_token_cache.sv
module wt_token_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_we,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              sh_req_valid,
  input  logic              sh_req_ready,
  output logic [1:0]        sh_req_kind,
  output logic [ADDR_W-1:0] sh_req_addr,
  output logic [DATA_W-1:0] sh_req_wdata,
  output logic              sh_req_tok,
  input  logic              sh_rsp_valid,
  input  logic [DATA_W-1:0] sh_rsp_rdata,
  input  logic              sh_rsp_cacheable,
  input  logic              sh_rsp_token,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid;
  logic              lk_tok;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic              drop_en;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic              wr_en;

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_we(core_req_we), .core_req_addr(core_req_addr),
    .core_req_wdata(core_req_wdata),
    .core_rsp_valid(core_rsp_valid), .core_rsp_rdata(core_rsp_rdata),
    .sh_req_valid(sh_req_valid), .sh_req_ready(sh_req_ready),
    .sh_req_kind(sh_req_kind), .sh_req_addr(sh_req_addr),
    .sh_req_wdata(sh_req_wdata), .sh_req_tok(sh_req_tok),
    .sh_rsp_valid(sh_rsp_valid), .sh_rsp_rdata(sh_rsp_rdata),
    .sh_rsp_cacheable(sh_rsp_cacheable), .sh_rsp_token(sh_rsp_token),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tok(lk_tok),
    .lk_tag(lk_tag), .lk_data(lk_data),
    .drop_en(drop_en), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .wr_en(wr_en)
  );

  wtc_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tok(lk_tok),
    .lk_tag(lk_tag), .lk_data(lk_data),
    .drop_en(drop_en), .drop_idx(lk_idx),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_data(sh_rsp_rdata), .fill_tok(sh_rsp_token),
    .wr_en(wr_en), .wr_idx(lk_idx), .wr_data(core_req_wdata),
    .inv_en(inv_valid), .inv_idx(inv_addr[IDX_W-1:0]),
    .inv_tag(inv_addr[ADDR_W-1:IDX_W])
  );
endmodule

// File: tb/sim_wt_token_cache.sv
module sim_wt_token_cache;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_req_valid = 1'b0, core_req_we = 1'b0;
  logic [AW-1:0] core_req_addr = '0;
  logic [DW-1:0] core_req_wdata = '0;
  logic core_req_ready, core_rsp_valid;
  logic [DW-1:0] core_rsp_rdata;
  logic sh_req_valid, sh_req_tok;
  logic sh_req_ready = 1'b1;
  logic [1:0] sh_req_kind;
  logic [AW-1:0] sh_req_addr;
  logic [DW-1:0] sh_req_wdata;
  logic sh_rsp_valid = 1'b0, sh_rsp_cacheable = 1'b0, sh_rsp_token = 1'b0;
  logic [DW-1:0] sh_rsp_rdata = '0;
  logic inv_valid = 1'b0;
  logic [AW-1:0] inv_addr = '0;

  wt_token_cache u0 (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, rsp_seen = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: one entry per index
  logic          mv [8];
  logic          mt [8];
  logic [8:0]    mtag [8];
  logic [DW-1:0] md [8];

  // Expected shared-port messages and core responses
  logic [1:0]    q_kind [$];
  logic [AW-1:0] q_addr [$];
  logic [DW-1:0] q_data [$];
  logic          q_tok  [$];
  string         q_req  [$];
  logic [DW-1:0] q_rsp  [$];
  string         q_rreq [$];

  // Responder settings for the next read
  logic [DW-1:0] r_data = '0;
  logic r_cach = 1'b0, r_tok = 1'b0, r_inv = 1'b0;
  logic [AW-1:0] r_invaddr = '0;

  task automatic push_msg(logic [1:0] k, logic [AW-1:0] a, logic [DW-1:0] d, logic t, string req);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d);
    q_tok.push_back(t);  q_req.push_back(req);
  endtask

  // Ready pattern from an LFSR, changed just after each rising edge
  logic [15:0] lfsr = 16'hACE1;
  logic ready_free = 1'b1;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sh_req_ready = ready_free ? 1'b1 : (lfsr[0] | lfsr[1]);
  end

  // Monitor and shared-level responder, once per clock at the falling edge
  int rsp_cd = 0;
  logic inv_by_mon = 1'b0;
  logic hold_p = 1'b0;
  logic [1:0] hold_k;
  logic [AW-1:0] hold_a;
  initial begin
    forever begin
      @(negedge clk); #1;
      sh_rsp_valid = 1'b0;
      if (inv_by_mon) begin inv_valid = 1'b0; inv_by_mon = 1'b0; end
      if (rst_n) begin
        if (hold_p) begin
          chk("R10 hold valid", sh_req_valid, 1'b1);
          chk("R10 hold kind", sh_req_kind, hold_k);
          chk("R10 hold addr", sh_req_addr, hold_a);
        end
        hold_p = sh_req_valid && !sh_req_ready;
        hold_k = sh_req_kind; hold_a = sh_req_addr;
        if (core_req_valid && core_req_we && !sh_req_ready)
          chk("R5 store stalls", core_req_ready, 1'b0);
        if (core_rsp_valid) begin
          if (q_rsp.size() == 0) chk("R2 unexpected core response", 1'b1, 1'b0);
          else begin
            string rq;
            rq = q_rreq.pop_front();
            chk(rq, core_rsp_rdata, q_rsp.pop_front());
          end
          rsp_seen++;
        end
        if (rsp_cd > 0) begin
          if (rsp_cd == 2 && r_inv) begin
            inv_valid = 1'b1; inv_addr = r_invaddr; inv_by_mon = 1'b1;
          end
          if (rsp_cd == 1) begin
            sh_rsp_valid = 1'b1; sh_rsp_rdata = r_data;
            sh_rsp_cacheable = r_cach; sh_rsp_token = r_tok;
          end
          rsp_cd--;
        end
        if (sh_req_valid && sh_req_ready) begin
          if (q_kind.size() == 0) chk("R2 unexpected shared message", 1'b1, 1'b0);
          else begin
            string rq;
            rq = q_req.pop_front();
            chk({rq, " kind"}, sh_req_kind, q_kind.pop_front());
            chk({rq, " addr"}, sh_req_addr, q_addr.pop_front());
            chk({rq, " data"}, sh_req_wdata, q_data.pop_front());
            chk({rq, " tok"},  sh_req_tok,  q_tok.pop_front());
          end
          if (sh_req_kind == 2'b00) rsp_cd = 2;
        end
      end
    end
  end

  task automatic do_load(logic [AW-1:0] a, logic [DW-1:0] d, logic cach, logic tk, logic invd, string req);
    logic [2:0] ix;
    int target;
    ix = a[2:0];
    if (mv[ix] && mtag[ix] == a[11:3]) begin
      q_rsp.push_back(md[ix]); q_rreq.push_back({req, " hit data"});
    end else begin
      if (mv[ix]) begin
        if (mt[ix]) push_msg(2'b10, {mtag[ix], ix}, '0, 1'b1, "R4 token return");
        mv[ix] = 1'b0; mt[ix] = 1'b0;
      end
      push_msg(2'b00, a, '0, 1'b0, {req, " read"});
      q_rsp.push_back(d); q_rreq.push_back({req, " fill data"});
      if (cach && !invd) begin mv[ix] = 1'b1; mt[ix] = tk; mtag[ix] = a[11:3]; md[ix] = d; end
    end
    r_data = d; r_cach = cach; r_tok = tk; r_inv = invd; r_invaddr = a;
    target = rsp_seen + 1;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_we = 1'b0; core_req_addr = a;
    @(posedge clk);
    @(negedge clk);
    core_req_valid = 1'b0;
    while (rsp_seen < target) @(negedge clk);
    r_inv = 1'b0;
  endtask

  task automatic do_store(logic [AW-1:0] a, logic [DW-1:0] d);
    logic [2:0] ix;
    logic h;
    ix = a[2:0];
    h = mv[ix] && mtag[ix] == a[11:3];
    push_msg(2'b01, a, d, h && mt[ix], "R5 write-through");
    if (h) md[ix] = d;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_we = 1'b1; core_req_addr = a; core_req_wdata = d;
    forever begin
      #2;
      if (core_req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    core_req_valid = 1'b0; core_req_we = 1'b0;
  endtask

  task automatic do_inv(logic [AW-1:0] a);
    logic [2:0] ix;
    ix = a[2:0];
    if (mv[ix] && mtag[ix] == a[11:3]) begin mv[ix] = 1'b0; mt[ix] = 1'b0; end
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; mt[i] = 1'b0; mtag[i] = '0; md[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1 core_req_ready", core_req_ready, 1'b1);
    chk("R1 core_rsp_valid", core_rsp_valid, 1'b0);
    chk("R1 sh_req_valid", sh_req_valid, 1'b0);

    // R3 miss with token grant, then R2 hit
    do_load(12'h010, 32'hA0A0_0001, 1'b1, 1'b1, 1'b0, "R3");
    do_load(12'h010, 32'h0, 1'b0, 1'b0, 1'b0, "R2");
    // R5 store on token line, R6 local update
    do_store(12'h010, 32'hB0B0_0002);
    do_load(12'h010, 32'h0, 1'b0, 1'b0, 1'b0, "R6");
    // R6 store miss allocates nothing; then read-only fill without token
    do_store(12'h123, 32'hC0C0_0003);
    do_load(12'h123, 32'hC0C0_0004, 1'b1, 1'b0, 1'b0, "R6 no-allocate");
    do_store(12'h123, 32'hC0C0_0005);
    // R4 victim holding token, then victim without token
    do_load(12'h018, 32'hD0D0_0006, 1'b1, 1'b0, 1'b0, "R4");
    do_load(12'h020, 32'hE0E0_0007, 1'b1, 1'b1, 1'b0, "R4 silent drop");
    // R7 non-cacheable response
    do_load(12'h031, 32'hF0F0_0008, 1'b0, 1'b1, 1'b0, "R7");
    do_load(12'h031, 32'hF0F0_0009, 1'b0, 1'b0, 1'b0, "R7 again");
    // R8 matching and non-matching invalidations
    do_inv(12'h123);
    do_inv(12'h028);
    do_load(12'h123, 32'h1111_000A, 1'b1, 1'b0, 1'b0, "R8 removed");
    do_load(12'h020, 32'h0, 1'b0, 1'b0, 1'b0, "R8 untouched");
    do_store(12'h020, 32'h2222_000B);
    // R9 invalidation during an outstanding miss
    do_load(12'h045, 32'h3333_000C, 1'b1, 1'b1, 1'b1, "R9");
    do_load(12'h045, 32'h3333_000D, 1'b1, 1'b1, 1'b0, "R9 refetch");
    do_store(12'h045, 32'h3333_000E);
    // R10 back-pressure mix
    ready_free = 1'b0;
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] a;
      a = AW'(12'h100 + (k * 5) % 19);
      if (k % 3 == 0) do_store(a, 32'h5000_0000 + k);
      else do_load(a, 32'h6000_0000 + k, (k % 4) != 1, (k % 2) == 0, (k % 7) == 3, "R10 mix");
    end
    ready_free = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 all messages seen", q_kind.size(), 0);
    chk("R2 all responses seen", q_rsp.size(), 0);
    finish_run();
  end
endmodule